// File: doc/BRIEF.md
# Accumulator ALU with Immediate Forms

This block holds all the arithmetic and logic of an accumulator-style datapath. Each cycle it takes the current accumulator, one register operand, an 8-bit immediate byte and an already decoded operation (a 3-bit group plus a 3-bit selector). It returns the next accumulator value. There is no carry or overflow flag. Software recovers a carry by adding, then running an unsigned less-than compare of the sum against the addend. The compare leaves 0 or 1 in the accumulator.

The operations fall into five groups:

| Group | Name | What it does |
|-------|------|--------------|
| 0 | unary | Eight operations on the accumulator alone. |
| 1 | register | Eight operations between the accumulator and the register operand. |
| 2 | less-than | Unsigned compare of the accumulator against the register operand. |
| 3 | immediate logic | Logic operations with the immediate byte. |
| 4 | immediate arithmetic | Add, shift and rotate operations; the immediate byte itself carries the sub-operation. |

Add-immediate has two byte forms. One adds a 7-bit non-negative constant. The other adds a negative constant from -64 to -1. Byte patterns with no meaning, and group or selector values with no meaning, raise an error output and leave the accumulator unchanged.

Parameter `WIDTH` sets the data width (at least 8, default 16). Parameter `REG_OUT` selects a registered result (the default) or a purely combinational one.

Top module: `acc_alu_core`

## Requirements
- R1: Group 0 (unary) produces, for selector 0 to 7 in order: zero, acc shifted left by one, logical right shift by one, arithmetic right shift by one, acc+1, acc-1, bitwise NOT of acc, and the two's-complement negation of acc. All results wrap modulo 2^WIDTH.
- R2: Group 1 with selector 0 to 4 produces, in order: acc+opnd, acc-opnd, acc AND opnd, acc OR opnd, acc XOR opnd, modulo 2^WIDTH.
- R3: Group 1 with selector 5, 6 and 7 shifts acc by the low log2(WIDTH) bits of opnd. Selector 5 shifts left, 6 shifts right logically and 7 shifts right arithmetically. The upper bits of opnd have no effect.
- R4: Group 2 produces 1 when acc is below opnd as unsigned numbers, and 0 otherwise; the selector is ignored. After a group-1 add, comparing the sum against the addend yields the carry out of that add.
- R5: Group 3 with selector 0, 1 or 2 produces acc AND, OR or XOR the immediate byte, zero-extended to WIDTH bits.
- R6: Group 4 with an immediate byte whose bit 7 is 0 produces acc plus the low 7 bits, a value from 0 to 127.
- R7: Group 4 with an immediate byte whose bits 7:6 are 11 produces acc plus the byte taken as a signed 8-bit number, a value from -64 to -1.
- R8: Group 4 with an immediate byte of the form 100ooiii acts on acc by the 3-bit amount iii. The 2-bit field oo selects: 0 rotate left, 1 shift left, 2 logical shift right, 3 arithmetic shift right.
- R9: The following inputs raise err and produce acc unchanged: a group-4 byte of form 101xxxxx, group 3 with selector 3 to 7, and groups 5 to 7. Every other input leaves err at 0.
- R10: With REG_OUT=1, res and err appear one clock after their inputs. A synchronous active-high reset clears both to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| acc_i | input | WIDTH | Current accumulator |
| opnd_i | input | WIDTH | Register operand |
| imm_i | input | 8 | Immediate byte |
| grp_i | input | 3 | Operation group (0 to 7) |
| sel_i | input | 3 | Operation selector within the group |
| res_o | output | WIDTH | New accumulator value |
| err_o | output | 1 | Illegal operation indicator |

## Verification
On every cycle the assertions check the following:
- A compare result is only ever 0 or 1.
- Negation and complement keep their algebraic relations with the input accumulator.
- An error always comes with an unchanged accumulator.
- Groups 0 to 2 never raise an error.
- A registered error reports the accumulator from the previous cycle.

The exact values of each arithmetic, shift and rotate form need the bench's sweeps against its own arithmetic model. So do the choice between the two add-immediate encodings and the add-then-compare carry recovery.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int GRP_W = 3;
  localparam int SEL_W = 3;

  localparam logic [GRP_W-1:0] GRP_UNARY  = 3'd0;
  localparam logic [GRP_W-1:0] GRP_REG    = 3'd1;
  localparam logic [GRP_W-1:0] GRP_LESS   = 3'd2;
  localparam logic [GRP_W-1:0] GRP_IMMLOG = 3'd3;
  localparam logic [GRP_W-1:0] GRP_IMMAR  = 3'd4;

  typedef enum logic [SEL_W-1:0] {
    UN_ZERO = 3'd0, UN_SHL1 = 3'd1, UN_SHR1 = 3'd2, UN_SAR1 = 3'd3,
    UN_INC  = 3'd4, UN_DEC  = 3'd5, UN_NOT  = 3'd6, UN_NEG  = 3'd7
  } unary_op_e;

  typedef enum logic [SEL_W-1:0] {
    RG_ADD = 3'd0, RG_SUB = 3'd1, RG_AND = 3'd2, RG_OR  = 3'd3,
    RG_XOR = 3'd4, RG_SHL = 3'd5, RG_SHR = 3'd6, RG_SAR = 3'd7
  } reg_op_e;

  typedef enum logic [1:0] {
    IS_ROL = 2'd0, IS_SHL = 2'd1, IS_SHR = 2'd2, IS_SAR = 2'd3
  } imm_shift_e;

endpackage

// File: rtl/acc_alu_unary.sv
module acc_alu_unary
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] res
);

  unary_op_e op;

  always_comb begin
    op = unary_op_e'(sel);
    unique case (op)
      UN_ZERO: res = '0;
      UN_SHL1: res = {acc[WIDTH-2:0], 1'b0};
      UN_SHR1: res = {1'b0, acc[WIDTH-1:1]};
      UN_SAR1: res = {acc[WIDTH-1], acc[WIDTH-1:1]};
      UN_INC:  res = acc + WIDTH'(1);
      UN_DEC:  res = acc - WIDTH'(1);
      UN_NOT:  res = ~acc;
      UN_NEG:  res = ~acc + WIDTH'(1);
      default: res = acc;
    endcase
  end

endmodule

// File: rtl/acc_alu_regop.sv
module acc_alu_regop
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] opnd,
  input  logic [SEL_W-1:0] sel,
  output logic [WIDTH-1:0] res,
  output logic [WIDTH-1:0] lt_res
);

  localparam int SH_W = $clog2(WIDTH);

  logic [SH_W-1:0] amt;
  reg_op_e         op;
  logic            below;

  assign amt   = opnd[SH_W-1:0];
  assign below = (acc < opnd);

  always_comb begin
    op = reg_op_e'(sel);
    unique case (op)
      RG_ADD:  res = acc + opnd;
      RG_SUB:  res = acc - opnd;
      RG_AND:  res = acc & opnd;
      RG_OR:   res = acc | opnd;
      RG_XOR:  res = acc ^ opnd;
      RG_SHL:  res = acc << amt;
      RG_SHR:  res = acc >> amt;
      RG_SAR:  res = $unsigned($signed(acc) >>> amt);
      default: res = acc;
    endcase
  end

  assign lt_res = WIDTH'(below);

endmodule

// File: rtl/acc_alu_immop.sv
module acc_alu_immop
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [7:0]       imm,
  input  logic [SEL_W-1:0] log_sel,
  output logic [WIDTH-1:0] log_res,
  output logic             log_bad,
  output logic [WIDTH-1:0] ar_res,
  output logic             ar_bad
);

  logic [WIDTH-1:0]   imm_z;
  logic [WIDTH-1:0]   imm_s;
  logic [WIDTH-1:0]   imm_lo7;
  logic [2:0]         amt;
  logic [2*WIDTH-1:0] dbl;
  imm_shift_e         sop;

  assign imm_z   = WIDTH'(imm);
  assign imm_s   = WIDTH'(signed'(imm));
  assign imm_lo7 = WIDTH'(imm[6:0]);
  assign amt     = imm[2:0];
  assign dbl     = {acc, acc} << amt;

  // logic forms with the zero-extended byte
  always_comb begin
    log_bad = 1'b0;
    unique case (log_sel)
      3'd0:    log_res = acc & imm_z;
      3'd1:    log_res = acc | imm_z;
      3'd2:    log_res = acc ^ imm_z;
      default: begin
        log_res = acc;
        log_bad = 1'b1;
      end
    endcase
  end

  // the byte selects add, shift/rotate, or is illegal
  always_comb begin
    sop    = imm_shift_e'(imm[4:3]);
    ar_bad = 1'b0;
    if (!imm[7]) begin
      ar_res = acc + imm_lo7;
    end else if (imm[6]) begin
      ar_res = acc + imm_s;
    end else if (!imm[5]) begin
      unique case (sop)
        IS_ROL:  ar_res = dbl[2*WIDTH-1:WIDTH];
        IS_SHL:  ar_res = acc << amt;
        IS_SHR:  ar_res = acc >> amt;
        IS_SAR:  ar_res = $unsigned($signed(acc) >>> amt);
        default: ar_res = acc;
      endcase
    end else begin
      ar_res = acc;
      ar_bad = 1'b1;
    end
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  input  logic [7:0]       imm_i,
  input  logic [GRP_W-1:0] grp_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [WIDTH-1:0] res_o,
  output logic             err_o
);

  logic [WIDTH-1:0] un_res, rg_res, lt_res, lg_res, ar_res;
  logic             lg_bad, ar_bad;
  logic [WIDTH-1:0] nxt_res;
  logic             nxt_err;

  acc_alu_unary #(.WIDTH(WIDTH)) u_unary (
    .acc (acc_i),
    .sel (sel_i),
    .res (un_res)
  );

  acc_alu_regop #(.WIDTH(WIDTH)) u_regop (
    .acc    (acc_i),
    .opnd   (opnd_i),
    .sel    (sel_i),
    .res    (rg_res),
    .lt_res (lt_res)
  );

  acc_alu_immop #(.WIDTH(WIDTH)) u_immop (
    .acc     (acc_i),
    .imm     (imm_i),
    .log_sel (sel_i),
    .log_res (lg_res),
    .log_bad (lg_bad),
    .ar_res  (ar_res),
    .ar_bad  (ar_bad)
  );

  always_comb begin
    nxt_res = acc_i;
    nxt_err = 1'b0;
    unique case (grp_i)
      GRP_UNARY:  nxt_res = un_res;
      GRP_REG:    nxt_res = rg_res;
      GRP_LESS:   nxt_res = lt_res;
      GRP_IMMLOG: begin
        nxt_res = lg_res;
        nxt_err = lg_bad;
      end
      GRP_IMMAR:  begin
        nxt_res = ar_res;
        nxt_err = ar_bad;
      end
      default:    nxt_err = 1'b1;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] res_q;
      logic             err_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          res_q <= '0;
          err_q <= 1'b0;
        end else begin
          res_q <= nxt_res;
          err_q <= nxt_err;
        end
      end
      assign res_o = res_q;
      assign err_o = err_q;

      AST_ERR_PAST_ACC: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (res_o == $past(acc_i))) else $error("err without held acc"); // R10
    end else begin : g_comb
      assign res_o = nxt_res;
      assign err_o = nxt_err;
    end
  endgenerate

  AST_LESS_IS_BIT: assert property (@(posedge clk) disable iff (rst)
    (grp_i == GRP_LESS) |-> (nxt_res[WIDTH-1:1] == '0)) else $error("compare not 0/1"); // R4
  AST_NEG_SUMS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (grp_i == GRP_UNARY && sel_i == 3'd7) |-> ((nxt_res + acc_i) == '0)) else $error("neg"); // R1
  AST_NOT_XOR_ONES: assert property (@(posedge clk) disable iff (rst)
    (grp_i == GRP_UNARY && sel_i == 3'd6) |-> ((nxt_res ^ acc_i) == '1)) else $error("not"); // R1
  AST_ERR_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    nxt_err |-> (nxt_res == acc_i)) else $error("err changed acc"); // R9
  AST_NO_ERR_BASIC: assert property (@(posedge clk) disable iff (rst)
    (grp_i <= GRP_LESS) |-> !nxt_err) else $error("spurious err"); // R9

endmodule

// File: tb/acc_alu_core_test.sv
module acc_alu_core_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] acc_i = '0;
  logic [W-1:0] opnd_i = '0;
  logic [7:0]   imm_i = '0;
  logic [2:0]   grp_i = '0;
  logic [2:0]   sel_i = '0;
  logic [W-1:0] res_o;
  logic         err_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core #(.WIDTH(W), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .imm_i(imm_i),
    .grp_i(grp_i), .sel_i(sel_i), .res_o(res_o), .err_o(err_o)
  );

  function automatic logic [7:0] sar8(input logic [7:0] a, input int n);
    logic [15:0] ext;
    ext = {{8{a[7]}}, a} >> n;
    return ext[7:0];
  endfunction

  // returns {err, res}
  function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                       input logic [7:0] im, input int g, input int s);
    int ai, bi, r;
    logic e;
    ai = int'(a); bi = int'(b); e = 1'b0; r = ai;
    case (g)
      0: case (s)
           0: r = 0;
           1: r = ai * 2;
           2: r = ai / 2;
           3: r = int'(sar8(a, 1));
           4: r = ai + 1;
           5: r = ai + 255;
           6: r = 255 - ai;
           default: r = 256 - ai;
         endcase
      1: case (s)
           0: r = ai + bi;
           1: r = ai + 256 - bi;
           2: r = int'(a & b);
           3: r = int'(a | b);
           4: r = int'(a ^ b);
           5: r = ai * (1 << (bi % 8));
           6: r = ai / (1 << (bi % 8));
           default: r = int'(sar8(a, bi % 8));
         endcase
      2: r = (ai < bi) ? 1 : 0;
      3: case (s)
           0: r = int'(a & im);
           1: r = int'(a | im);
           2: r = int'(a ^ im);
           default: e = 1'b1;
         endcase
      4: begin
        if (im < 8'h80) r = ai + int'(im);
        else if (im >= 8'hC0) r = ai + int'(im) - 256;
        else if (im < 8'hA0) begin
          case (int'(im[4:3]))
            0: r = ai * (1 << int'(im[2:0])) + ai / (1 << (8 - int'(im[2:0])));
            1: r = ai * (1 << int'(im[2:0]));
            2: r = ai / (1 << int'(im[2:0]));
            default: r = int'(sar8(a, int'(im[2:0])));
          endcase
        end else e = 1'b1;
      end
      default: e = 1'b1;
    endcase
    r = ((r % 256) + 256) % 256;
    return {e, r[7:0]};
  endfunction

  // entered at a falling edge; drives, then checks at the next falling edge
  task automatic run(input logic [7:0] a, input logic [7:0] b, input logic [7:0] im,
                     input int g, input int s, input string tag);
    logic [8:0] exp;
    exp = model(a, b, im, g, s);
    acc_i = a; opnd_i = b; imm_i = im; grp_i = 3'(g); sel_i = 3'(s);
    @(negedge clk);
    total++;
    if (res_o !== exp[7:0] || err_o !== exp[8]) begin
      bad++;
      $display("FAIL %s: g=%0d s=%0d acc=%h opnd=%h imm=%h got res=%h err=%b exp res=%h err=%b",
               tag, g, s, a, b, im, res_o, err_o, exp[7:0], exp[8]);
    end
  endtask

  task automatic check_reset(input string tag);
    total++;
    if (res_o !== '0 || err_o !== 1'b0) begin
      bad++;
      $display("FAIL %s: reset state got res=%h err=%b exp res=00 err=0", tag, res_o, err_o);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] sum;
    grp_i = 3'd5;
    acc_i = 8'h5A;
    repeat (3) @(negedge clk);
    check_reset("R10");
    rst = 1'b0;

    // R1 unary, exhaustive
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 256; a++)
        run(8'(a), 8'h00, 8'h00, 0, s, "R1");

    // R2 / R3 register ops
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 256; a += 5)
        for (int b = 0; b < 256; b += 7)
          run(8'(a), 8'(b), 8'h00, 1, s, (s < 5) ? "R2" : "R3");

    // R4 unsigned compare, including equal operands
    for (int a = 0; a < 256; a += 3)
      for (int b = 0; b < 256; b += 3)
        run(8'(a), 8'(b), 8'h00, 2, a % 8, "R4");

    // R4 carry recovery: add, then compare the sum with the addend
    for (int a = 0; a < 256; a += 37)
      for (int b = 0; b < 256; b += 41) begin
        run(8'(a), 8'(b), 8'h00, 1, 0, "R2");
        sum = res_o;
        run(sum, 8'(b), 8'h00, 2, 0, "R4");
        total++;
        if (res_o !== 8'((a + b) / 256)) begin
          bad++;
          $display("FAIL R4: carry of %h+%h got %h exp %h", a, b, res_o, (a + b) / 256);
        end
      end

    // R5 / R9 immediate logic
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 256; a += 17)
        for (int im = 0; im < 256; im++)
          run(8'(a), 8'hFF, 8'(im), 3, s, (s < 3) ? "R5" : "R9");

    // R6 / R7 / R8 / R9 immediate arithmetic, every byte
    for (int a = 0; a < 256; a += 5)
      for (int im = 0; im < 256; im++)
        run(8'(a), 8'h3C, 8'(im), 4, 7, (im < 128) ? "R6" : (im >= 192) ? "R7" :
                                       (im < 160) ? "R8" : "R9");

    // R9 illegal groups
    for (int g = 5; g < 8; g++)
      for (int a = 0; a < 256; a += 51)
        run(8'(a), 8'h11, 8'h22, g, a % 8, "R9");

    // R10 reset in the middle of a run
    acc_i = 8'hAB; grp_i = 3'd6;
    rst = 1'b1;
    @(negedge clk);
    check_reset("R10");
    rst = 1'b0;
    run(8'h80, 8'h01, 8'h00, 0, 7, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule